// File: doc/BRIEF.md
# Bicolor LED Matrix Scan Driver

This block drives a grid of two-colour LEDs. Each LED is a red and a green die wired anti-parallel between one line wire and one column wire. The colour comes from the direction of the drive: the column is high and the line low for green, and the column is low and the line high for red. The driver scans one column at a time. The columns get equal slices of a refresh period that is set by two parameters, the system clock frequency and the refresh rate. In the active column it drives every line according to that LED's 2-bit colour code.

Each column slot is cut into 100 equal steps. A 7-bit brightness input sets how many steps from the start of the slot are lit; values above 100 count as 100. The lit window is split into two halves. In the first half the active column is driven high, which lights green. In the second half it is driven low, which lights red. An LED coded red plus green is lit in both halves. An LED coded green or red is lit in its own half only. Outside the lit window, and for dark LEDs, the line drivers are released to high impedance through their enables. Each column also has its own enable, so idle columns float and cannot light anything.

Top module: `bicolor_matrix_drv`

## Requirements
- R1: The LED at line l, column c takes its colour code from bits [2*(l*N_COL+c)+1 : 2*(l*N_COL+c)] of the state input. The codes are 00 dark, 01 green, 10 red and 11 red plus green.
- R2: A column slot lasts TICK_CYC*100 cycles, where TICK_CYC = CLK_HZ/(REFRESH_HZ*N_COL*100). One slot step lasts TICK_CYC cycles. Columns are visited in ascending order 0 to N_COL-1 and then wrap to 0.
- R3: At most one column enable is asserted at any time, and it is the enable of the active column. No line enable is asserted while all column enables are released.
- R4: With step index p inside the slot (0..99) and brightness saturated at 100 (b = min(intensity,100)), the window is lit when p < b. The column enable is asserted only while the window is lit.
- R5: In the green half of the lit window (2*p < b), the active column output is 1. A line whose code is 01 or 11 has its enable asserted with its output at 0.
- R6: In the red half of the lit window (2*p >= b), the active column output is 0. A line whose code is 10 or 11 has its enable asserted with its output at 1.
- R7: A line whose code is 00, or whose colour does not match the current half, has its enable released and its output at 0. While a line enable is released, its line output is 0.
- R8: During reset every enable and every output is 0. The first cycle after reset starts at step 0 of column 0.
- R9: A brightness of 0 keeps all enables released for the whole frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| intensity_i | input | 7 | Global brightness in percent; values above 100 count as 100 |
| led_state_i | input | N_LINE*N_COL*2 | Colour code of every LED |
| col_o | output | N_COL | Column drive levels |
| col_oe_o | output | N_COL | Column driver enables |
| line_o | output | N_LINE | Line drive levels |
| line_oe_o | output | N_LINE | Line driver enables |

## Verification
The outputs are combinational functions of the scan counters and the two data inputs. A change of brightness or colour therefore shows in the same cycle, and the counters move one step every TICK_CYC clock edges. The bench counts the edges since reset was released. From that count alone it computes the step index and the column by division and modulo. It samples on the falling edge, so the expected drive of every line and column is due in exactly the cycle the check looks at. A small configuration with three columns and two cycles per step lets every cycle of whole frames be compared under several brightness and colour patterns.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    typedef enum logic [1:0] {
        LED_DARK = 2'b00,
        LED_GRN  = 2'b01,
        LED_RED  = 2'b10,
        LED_BOTH = 2'b11
    } led_code_e;

    typedef struct packed {
        logic lit;
        logic grn_half;
    } win_t;

    localparam int STEPS = 100;

    function automatic logic [6:0] sat_bright(input logic [6:0] v);
        return (v > 7'd100) ? 7'd100 : v;
    endfunction

endpackage

// File: rtl/bcm_scan_timer.sv
module bcm_scan_timer #(
    parameter int N_COL    = 4,
    parameter int TICK_CYC = 1250,
    localparam int CW      = (N_COL > 1) ? $clog2(N_COL) : 1,
    localparam int TW      = $clog2(TICK_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [6:0]    step_o,
    output logic [CW-1:0] col_o
);
    import bcm_pkg::*;

    logic [TW-1:0] tick_q;
    logic [6:0]    step_q;
    logic [CW-1:0] col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            step_q <= '0;
            col_q  <= '0;
        end else if (tick_q == TW'(TICK_CYC - 1)) begin
            tick_q <= '0;
            if (step_q == 7'(STEPS - 1)) begin
                step_q <= '0;
                col_q  <= (col_q == CW'(N_COL - 1)) ? '0 : col_q + 1'b1;
            end else begin
                step_q <= step_q + 7'd1;
            end
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign step_o = step_q;
    assign col_o  = col_q;

    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        step_q < 7'(STEPS));
    // R2
    col_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (col_q != $past(col_q)) |-> ($past(step_q) == 7'(STEPS - 1)));
    // R8
    reset_start_chk: assert property (@(posedge clk)
        rst |=> (step_q == 7'd0 && col_q == '0));

endmodule

// File: rtl/bcm_window.sv
module bcm_window (
    input  logic             rst,
    input  logic [6:0]       step_i,
    input  logic [6:0]       intensity_i,
    output bcm_pkg::win_t    win_o
);
    import bcm_pkg::*;

    logic [6:0] bright;

    always_comb begin
        bright         = sat_bright(intensity_i);
        win_o.lit      = !rst && (step_i < bright);
        win_o.grn_half = ({1'b0, step_i} << 1) < {1'b0, bright};
    end

endmodule

// File: rtl/bcm_line_drive.sv
module bcm_line_drive #(
    parameter int N_COL  = 4,
    parameter int N_LINE = 2,
    localparam int CW    = (N_COL > 1) ? $clog2(N_COL) : 1,
    localparam int SW    = N_LINE * N_COL * 2
) (
    input  logic [SW-1:0]   state_i,
    input  logic [CW-1:0]   col_i,
    input  bcm_pkg::win_t   win_i,
    output logic [N_LINE-1:0] line_o,
    output logic [N_LINE-1:0] line_oe_o
);
    import bcm_pkg::*;

    for (genvar l = 0; l < N_LINE; l++) begin : g_line
        led_code_e code;
        logic      on;
        always_comb begin
            code = led_code_e'(state_i[2*(l*N_COL + int'(col_i)) +: 2]);
            if (win_i.grn_half)
                on = (code == LED_GRN) || (code == LED_BOTH);
            else
                on = (code == LED_RED) || (code == LED_BOTH);
            line_oe_o[l] = win_i.lit && on;
            line_o[l]    = win_i.lit && on && !win_i.grn_half;
        end
    end

endmodule

// File: rtl/bicolor_matrix_drv.sv
module bicolor_matrix_drv #(
    parameter int N_COL      = 4,
    parameter int N_LINE     = 2,
    parameter int CLK_HZ     = 125_000_000,
    parameter int REFRESH_HZ = 250,
    localparam int TICK_RAW  = CLK_HZ / (REFRESH_HZ * N_COL * bcm_pkg::STEPS),
    localparam int TICK_CYC  = (TICK_RAW < 1) ? 1 : TICK_RAW,
    localparam int CW        = (N_COL > 1) ? $clog2(N_COL) : 1,
    localparam int SW        = N_LINE * N_COL * 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [6:0]        intensity_i,
    input  logic [SW-1:0]     led_state_i,
    output logic [N_COL-1:0]  col_o,
    output logic [N_COL-1:0]  col_oe_o,
    output logic [N_LINE-1:0] line_o,
    output logic [N_LINE-1:0] line_oe_o
);
    import bcm_pkg::*;

    logic [6:0]    step;
    logic [CW-1:0] col;
    win_t          win;

    bcm_scan_timer #(.N_COL(N_COL), .TICK_CYC(TICK_CYC)) u_timer (
        .clk(clk), .rst(rst), .step_o(step), .col_o(col)
    );

    bcm_window u_window (
        .rst(rst), .step_i(step), .intensity_i(intensity_i), .win_o(win)
    );

    bcm_line_drive #(.N_COL(N_COL), .N_LINE(N_LINE)) u_lines (
        .state_i(led_state_i), .col_i(col), .win_i(win),
        .line_o(line_o), .line_oe_o(line_oe_o)
    );

    for (genvar c = 0; c < N_COL; c++) begin : g_col
        always_comb begin
            col_oe_o[c] = win.lit && (col == CW'(c));
            col_o[c]    = win.lit && win.grn_half && (col == CW'(c));
        end
    end

    // R3
    one_col_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col_oe_o));
    // R3
    line_needs_col_chk: assert property (@(posedge clk) disable iff (rst)
        (line_oe_o != '0) |-> (col_oe_o != '0));
    // R6
    polarity_chk: assert property (@(posedge clk) disable iff (rst)
        (line_o != '0) |-> (col_o == '0));
    // R7
    released_low_chk: assert property (@(posedge clk) disable iff (rst)
        (line_o & ~line_oe_o) == '0);
    // R9
    dark_chk: assert property (@(posedge clk) disable iff (rst)
        (intensity_i == 7'd0) |-> (col_oe_o == '0 && line_oe_o == '0));

endmodule

// File: tb/bicolor_matrix_drv_tb.sv
module bicolor_matrix_drv_tb;
    localparam int NC   = 3;
    localparam int NL   = 2;
    localparam int REF  = 1000;
    localparam int TICK = 2;
    localparam int CLK  = TICK * 100 * NC * REF;
    localparam int SW   = NC * NL * 2;
    localparam int FRAME = TICK * 100 * NC;

    logic clk = 0;
    logic rst = 1;
    logic [6:0] inten = 7'd50;
    logic [SW-1:0] st = '0;
    logic [NC-1:0] col_o, col_oe;
    logic [NL-1:0] line_o, line_oe;
    int n = 0;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bicolor_matrix_drv #(.N_COL(NC), .N_LINE(NL), .CLK_HZ(CLK), .REFRESH_HZ(REF)) u_dut (
        .clk(clk), .rst(rst), .intensity_i(inten), .led_state_i(st),
        .col_o(col_o), .col_oe_o(col_oe), .line_o(line_o), .line_oe_o(line_oe)
    );

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    task automatic check_now();
        int p, c, b;
        bit lit, grn;
        logic [NC-1:0] e_coe, e_co;
        logic [NL-1:0] e_loe, e_lo;
        p = (n / TICK) % 100;
        c = (n / (TICK * 100)) % NC;
        b = (inten > 100) ? 100 : int'(inten);
        lit = p < b;
        grn = 2 * p < b;
        e_coe = '0; e_co = '0;
        if (lit) begin
            e_coe[c] = 1'b1;
            e_co[c]  = grn;
        end
        for (int l = 0; l < NL; l++) begin
            logic [1:0] code;
            code = st[2*(l*NC + c) +: 2];
            e_loe[l] = lit && (grn ? code[0] : code[1]);
            e_lo[l]  = e_loe[l] && !grn;
        end
        total++;
        if (col_oe !== e_coe || col_o !== e_co) begin
            bad++;
            $display("FAIL R2/R3/R4 n=%0d col_oe=%b col=%b expected %b %b",
                     n, col_oe, col_o, e_coe, e_co);
        end
        total++;
        if (line_oe !== e_loe || line_o !== e_lo) begin
            bad++;
            $display("FAIL R1/R5/R6/R7 n=%0d line_oe=%b line=%b expected %b %b",
                     n, line_oe, line_o, e_loe, e_lo);
        end
    endtask

    task automatic run_frame(input logic [6:0] i, input logic [SW-1:0] s);
        @(negedge clk);
        inten = i;
        st = s;
        for (int k = 0; k < FRAME; k++) begin
            #0.1;
            check_now();
            @(negedge clk);
        end
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    bad++; total++;
                    $display("FAIL watchdog expired actual=hung expected=finished");
                    $display("test done: total=%0d bad=%0d", total, bad);
                    $finish;
                end
            end
        join_none

        st = {SW{1'b1}};
        repeat (3) @(negedge clk);
        // R8: dark during reset
        total++;
        if (col_oe !== '0 || line_oe !== '0 || col_o !== '0 || line_o !== '0) begin
            bad++;
            $display("FAIL R8 in reset oe=%b/%b expected 0/0", col_oe, line_oe);
        end
        rst = 0;
        @(negedge clk);
        // R8: first cycle is column 0, step 0, green half
        total++;
        if (col_oe !== 3'b001 || col_o !== 3'b001 || line_oe !== 2'b11 || line_o !== 2'b00) begin
            bad++;
            $display("FAIL R8 after reset col_oe=%b col=%b line_oe=%b expected 001 001 11",
                     col_oe, col_o, line_oe);
        end

        foreach (inten_list[j]) begin
            run_frame(inten_list[j], 12'b11_10_01_00_01_10);
            run_frame(inten_list[j], 12'b00_01_10_11_11_00);
            run_frame(inten_list[j], {SW{1'b1}});
        end
        // R9: brightness 0 keeps everything dark
        run_frame(7'd0, {SW{1'b1}});
        // R4: above 100 saturates like 100
        run_frame(7'd127, 12'b10_10_01_01_11_11);
        // R7: all dark codes
        run_frame(7'd100, '0);

        // R8: reset mid-frame restarts at column 0
        @(negedge clk);
        rst = 1;
        inten = 7'd40;
        st = 12'b01_01_01_01_01_01;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        total++;
        if (col_oe !== 3'b001 || line_oe !== 2'b11 || line_o !== 2'b00) begin
            bad++;
            $display("FAIL R8 restart col_oe=%b line_oe=%b expected 001 11", col_oe, line_oe);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [6:0] inten_list [6] = '{7'd1, 7'd37, 7'd50, 7'd99, 7'd100, 7'd3};

endmodule